// File: doc/BRIEF.md
# Condition Register and Branch Decision Unit

This block holds the branch-related state of a simple integer pipeline: a 32-bit condition register organised as eight 4-bit fields, a loop counter and a return-address register. Each cycle, at most one operation is presented with a valid strobe. A compare operation writes one whole field. A bit-logic operation combines two single condition bits into a third position. A count load sets the loop counter.

A branch operation is also possible. It is decided from a 5-bit control word. That word can decrement the counter and test it, test one condition bit, do both, or do neither. The unit returns the decision and the next fetch address, which is either the supplied target or the sequential address. When link is requested, the unit also stores the sequential address as a return address.

The surrounding pipeline supplies the operands, the current PC and the branch target. The unit does no fetching and computes no addresses other than PC+4. All state changes on the rising clock edge. All outputs come from registers.

Top module: `cr_branch_unit`

## Requirements
- R1: After a synchronous reset, the condition register, counter, link register, `taken`, `next_pc` and `br_done` are all zero.
- R2: A compare (`op_kind`=0) writes field `cmp_field` as follows. Bit 4f+0 is less-than, 4f+1 is greater-than, 4f+2 is equal and 4f+3 is summary-overflow. Exactly one of the first three bits is set. All other fields keep their value.
- R3: With `cmp_signed`=1, the operands are compared as two's complement. With `cmp_signed`=0, they are compared as unsigned.
- R4: The summary-overflow bit of the written field copies `sticky_ov`.
- R5: A bit-logic operation (`op_kind`=1) writes bit `bit_dst` with the result of `bit_fn` applied to bits `bit_a` and `bit_b`. The functions are 0 AND, 1 OR, 2 XOR and 3 NAND. All other bits are unchanged.
- R6: In a branch (`op_kind`=2), `br_ctl[4]`=1 ignores the condition. Otherwise, the branch requires condition bit `cond_sel` to equal `br_ctl[3]`.
- R7: If `br_ctl[2]`=1, the counter is neither changed nor tested. Otherwise, the counter is first decremented (modulo 2^CNT_W). The new value is then tested: with `br_ctl[1]`=1 the test passes on zero, and with `br_ctl[1]`=0 it passes on nonzero. The branch is taken only when both tests pass.
- R8: One cycle after a branch, `br_done` is 1 and `taken` holds the decision. `next_pc` then equals `target` if taken, and `pc`+4 otherwise. `br_done` is 0 after any other cycle.
- R9: A branch with `br_ctl[0]`=1 writes `pc`+4 into the link register, whether or not the branch is taken. Otherwise, the link register is unchanged.
- R10: A count load (`op_kind`=3) sets the counter to `count_in`.
- R11: While `op_valid` is 0, the condition register, counter and link register do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 0 compare, 1 bit logic, 2 branch, 3 count load |
| src_a | input | DATA_W | First compare operand |
| src_b | input | DATA_W | Second compare operand |
| cmp_signed | input | 1 | 1 for a signed compare |
| cmp_field | input | 3 | Field written by a compare |
| sticky_ov | input | 1 | Sticky overflow copied into the field |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_dst | input | 5 | Destination bit index |
| bit_fn | input | 2 | Bit function select |
| br_ctl | input | 5 | Branch control word |
| cond_sel | input | 5 | Condition bit tested by a branch |
| pc | input | ADDR_W | Address of the branch |
| target | input | ADDR_W | Branch target address |
| count_in | input | CNT_W | Counter load value |
| cr_out | output | 32 | Condition register |
| count_out | output | CNT_W | Loop counter |
| link_out | output | ADDR_W | Link register |
| taken | output | 1 | Decision of the last branch |
| next_pc | output | ADDR_W | Next fetch address of the last branch |
| br_done | output | 1 | Branch result valid |

## Verification
Compares are swept over a grid of operands: zero, one, the most positive value, the most negative value, all-ones and a small value. The grid is run in both signedness modes, which separates the signed order from the unsigned order exactly where the sign bit is set. The written field rotates through all eight positions, and the overflow flag alternates, so a wrong field or a leak into a neighbour is seen. Every bit function is tried with spread source and destination indices, on a register that already holds mixed contents. All 32 control words are tried with counter preloads of 0, 1, 2 and 5. This covers the wrap to all-ones, the decrement to zero and ordinary nonzero counts, under every pairing of count test and bit test.

// File: rtl/crb_pkg.sv
package crb_pkg;

  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    OP_CMP    = 2'd0,
    OP_BITOP  = 2'd1,
    OP_BRANCH = 2'd2,
    OP_LDCNT  = 2'd3
  } crb_op_e;

  typedef enum logic [1:0] {
    BF_AND  = 2'd0,
    BF_OR   = 2'd1,
    BF_XOR  = 2'd2,
    BF_NAND = 2'd3
  } crb_bitfn_e;

  // lt sits in bit 0 of a field, so overflow is the top bit
  typedef struct packed {
    logic so;
    logic eq;
    logic gt;
    logic lt;
  } crb_field_t;

endpackage

// File: rtl/crb_compare.sv
module crb_compare
  import crb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              sticky,
  output crb_field_t        res
);

  logic less;

  always_comb begin
    if (is_signed) less = ($signed(a) < $signed(b));
    else           less = (a < b);
    res.eq = (a == b);
    res.lt = less;
    res.gt = !less && (a != b);
    res.so = sticky;
  end

endmodule

// File: rtl/crb_condreg.sv
module crb_condreg
  import crb_pkg::*;
#(
  parameter int NFIELD = 8,
  localparam int CR_W  = NFIELD * FIELD_W,
  localparam int BW    = $clog2(CR_W),
  localparam int SW    = $clog2(NFIELD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_we,
  input  logic [SW-1:0]   cmp_sel,
  input  crb_field_t      cmp_val,
  input  logic            bit_we,
  input  logic [BW-1:0]   src_a_idx,
  input  logic [BW-1:0]   src_b_idx,
  input  logic [BW-1:0]   dst_idx,
  input  logic [1:0]      fn,
  input  logic [BW-1:0]   rd_idx,
  output logic            rd_bit,
  output logic [CR_W-1:0] cr_q
);

  logic [FIELD_W-1:0] fld_q [NFIELD];
  logic sa, sb, bit_res;

  always_comb begin
    sa = cr_q[src_a_idx];
    sb = cr_q[src_b_idx];
    unique case (crb_bitfn_e'(fn))
      BF_AND:  bit_res = sa & sb;
      BF_OR:   bit_res = sa | sb;
      BF_XOR:  bit_res = sa ^ sb;
      default: bit_res = ~(sa & sb);
    endcase
  end

  assign rd_bit = cr_q[rd_idx];

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst) begin
        fld_q[g] <= '0;
      end else if (cmp_we && cmp_sel == SW'(g)) begin
        fld_q[g] <= cmp_val;
      end else if (bit_we && dst_idx[BW-1:2] == SW'(g)) begin
        fld_q[g][dst_idx[1:0]] <= bit_res;
      end
    end

    assign cr_q[g*FIELD_W +: FIELD_W] = fld_q[g];

    AST_CMP_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
      (cmp_we && cmp_sel == SW'(g)) |=> ($countones(fld_q[g][2:0]) == 1)); // R2

    AST_CMP_OTHER_FIELDS: assert property (@(posedge clk) disable iff (rst)
      (cmp_we && cmp_sel != SW'(g)) |=> $stable(fld_q[g])); // R2

    AST_SO_COPY: assert property (@(posedge clk) disable iff (rst)
      (cmp_we && cmp_sel == SW'(g)) |=> (fld_q[g][3] == $past(cmp_val.so))); // R4

    AST_BITOP_OTHER_FIELDS: assert property (@(posedge clk) disable iff (rst)
      (bit_we && dst_idx[BW-1:2] != SW'(g)) |=> $stable(fld_q[g])); // R5
  end

endmodule

// File: rtl/crb_branch_eval.sv
module crb_branch_eval #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_we,
  input  logic              ld_we,
  input  logic [CNT_W-1:0]  ld_val,
  input  logic [4:0]        ctl,
  input  logic              cond_bit,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  output logic [CNT_W-1:0]  ctr_q,
  output logic [ADDR_W-1:0] lr_q,
  output logic              taken_q,
  output logic [ADDR_W-1:0] npc_q,
  output logic              done_q
);

  logic [CNT_W-1:0]  ctr_next;
  logic [ADDR_W-1:0] seq_pc;
  logic ctr_ok, cond_ok, take;

  always_comb begin
    ctr_next = ctl[2] ? ctr_q : (ctr_q - CNT_W'(1));
    ctr_ok   = ctl[2] || ((ctr_next == '0) == ctl[1]);
    cond_ok  = ctl[4] || (cond_bit == ctl[3]);
    take     = ctr_ok && cond_ok;
    seq_pc   = pc + ADDR_W'(4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q   <= '0;
      lr_q    <= '0;
      taken_q <= 1'b0;
      npc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= br_we;
      if (ld_we) ctr_q <= ld_val;
      if (br_we) begin
        ctr_q   <= ctr_next;
        taken_q <= take;
        npc_q   <= take ? target : seq_pc;
        if (ctl[0]) lr_q <= seq_pc;
      end
    end
  end

  AST_COND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (br_we && !ctl[4] && (cond_bit != ctl[3])) |=> !taken_q); // R6

  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (br_we && ctl[2]) |=> $stable(ctr_q)); // R7

  AST_CTR_DEC: assert property (@(posedge clk) disable iff (rst)
    (br_we && !ctl[2]) |=> (ctr_q == $past(ctr_q) - CNT_W'(1))); // R7

  AST_NEXT_PC: assert property (@(posedge clk) disable iff (rst)
    br_we |=> (done_q && (npc_q == (taken_q ? $past(target) : $past(pc) + ADDR_W'(4))))); // R8

  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (br_we && ctl[0]) |=> (lr_q == $past(pc) + ADDR_W'(4))); // R9

  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(br_we && ctl[0])) |=> $stable(lr_q)); // R9

  AST_CTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> (ctr_q == $past(ld_val))); // R10

endmodule

// File: rtl/cr_branch_unit.sv
module cr_branch_unit
  import crb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int NFIELD = 8,
  localparam int CR_W  = NFIELD * FIELD_W,
  localparam int BW    = $clog2(CR_W),
  localparam int SW    = $clog2(NFIELD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              cmp_signed,
  input  logic [SW-1:0]     cmp_field,
  input  logic              sticky_ov,
  input  logic [BW-1:0]     bit_a,
  input  logic [BW-1:0]     bit_b,
  input  logic [BW-1:0]     bit_dst,
  input  logic [1:0]        bit_fn,
  input  logic [4:0]        br_ctl,
  input  logic [BW-1:0]     cond_sel,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic [CNT_W-1:0]  count_in,
  output logic [CR_W-1:0]   cr_out,
  output logic [CNT_W-1:0]  count_out,
  output logic [ADDR_W-1:0] link_out,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              br_done
);

  logic cmp_we, bit_we, br_we, ld_we, cond_bit;
  crb_field_t cmp_res;

  always_comb begin
    cmp_we = op_valid && (crb_op_e'(op_kind) == OP_CMP);
    bit_we = op_valid && (crb_op_e'(op_kind) == OP_BITOP);
    br_we  = op_valid && (crb_op_e'(op_kind) == OP_BRANCH);
    ld_we  = op_valid && (crb_op_e'(op_kind) == OP_LDCNT);
  end

  crb_compare #(.DATA_W(DATA_W)) u_cmp (
    .a         (src_a),
    .b         (src_b),
    .is_signed (cmp_signed),
    .sticky    (sticky_ov),
    .res       (cmp_res)
  );

  crb_condreg #(.NFIELD(NFIELD)) u_cr (
    .clk       (clk),
    .rst       (rst),
    .cmp_we    (cmp_we),
    .cmp_sel   (cmp_field),
    .cmp_val   (cmp_res),
    .bit_we    (bit_we),
    .src_a_idx (bit_a),
    .src_b_idx (bit_b),
    .dst_idx   (bit_dst),
    .fn        (bit_fn),
    .rd_idx    (cond_sel),
    .rd_bit    (cond_bit),
    .cr_q      (cr_out)
  );

  crb_branch_eval #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_br (
    .clk      (clk),
    .rst      (rst),
    .br_we    (br_we),
    .ld_we    (ld_we),
    .ld_val   (count_in),
    .ctl      (br_ctl),
    .cond_bit (cond_bit),
    .pc       (pc),
    .target   (target),
    .ctr_q    (count_out),
    .lr_q     (link_out),
    .taken_q  (taken),
    .npc_q    (next_pc),
    .done_q   (br_done)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(cr_out) && $stable(count_out) && $stable(link_out))); // R11

  AST_DONE_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
    !br_we |=> !br_done); // R8

endmodule

// File: tb/cr_branch_unit_test.sv
`timescale 1ns/1ps
module cr_branch_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [15:0] src_a = '0, src_b = '0;
  logic        cmp_signed = 1'b0;
  logic [2:0]  cmp_field = '0;
  logic        sticky_ov = 1'b0;
  logic [4:0]  bit_a = '0, bit_b = '0, bit_dst = '0;
  logic [1:0]  bit_fn = '0;
  logic [4:0]  br_ctl = '0;
  logic [4:0]  cond_sel = '0;
  logic [15:0] pc = '0, target = '0;
  logic [7:0]  count_in = '0;
  logic [31:0] cr_out;
  logic [7:0]  count_out;
  logic [15:0] link_out;
  logic        taken;
  logic [15:0] next_pc;
  logic        br_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] mcr;
  logic [7:0]  mctr;
  logic [15:0] mlr;

  always #10 clk = ~clk;

  cr_branch_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .src_a(src_a), .src_b(src_b), .cmp_signed(cmp_signed), .cmp_field(cmp_field),
    .sticky_ov(sticky_ov), .bit_a(bit_a), .bit_b(bit_b), .bit_dst(bit_dst),
    .bit_fn(bit_fn), .br_ctl(br_ctl), .cond_sel(cond_sel), .pc(pc),
    .target(target), .count_in(count_in), .cr_out(cr_out), .count_out(count_out),
    .link_out(link_out), .taken(taken), .next_pc(next_pc), .br_done(br_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one strobed operation, return after the result is registered
  task automatic issue(input logic [1:0] kind);
    op_kind  = kind;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [15:0] grid(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'h0005;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cr", cr_out, 32'h0);
    chk("R1 count", {24'h0, count_out}, 32'h0);
    chk("R1 link", {16'h0, link_out}, 32'h0);
    chk("R1 taken/done", {30'h0, taken, br_done}, 32'h0);
    chk("R1 next_pc", {16'h0, next_pc}, 32'h0);
    mcr = '0; mctr = '0; mlr = '0;

    // R2 R3 R4 compare sweep
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [15:0] a, b;
          logic lt, gt, eq, ov;
          int f;
          a = grid(i); b = grid(j);
          f = (i + j + s) % 8;
          ov = ((i + j) % 2) == 1;
          lt = (s == 1) ? ($signed(a) < $signed(b)) : (a < b);
          eq = (a == b);
          gt = !lt && !eq;
          src_a = a; src_b = b; cmp_signed = (s == 1);
          cmp_field = 3'(f); sticky_ov = ov;
          issue(2'd0);
          mcr[f*4 +: 4] = {ov, eq, gt, lt};
          chk("R2 R3 R4 compare field write", cr_out, mcr);
        end
      end
    end

    // R11 idle strobe low with compare inputs presented
    src_a = 16'h0001; src_b = 16'h0002; cmp_field = 3'd0; sticky_ov = 1'b1;
    op_kind = 2'd0; op_valid = 1'b0; count_in = 8'h77; br_ctl = 5'b00001;
    repeat (2) @(negedge clk);
    chk("R11 cr idle", cr_out, mcr);
    chk("R11 count idle", {24'h0, count_out}, {24'h0, mctr});
    chk("R11 link idle", {16'h0, link_out}, {16'h0, mlr});

    // R5 bit logic sweep
    for (int fn = 0; fn < 4; fn++) begin
      for (int k = 0; k < 16; k++) begin
        int ia, ib, id;
        logic va, vb, r;
        ia = (k * 7) % 32; ib = (k * 11 + 3) % 32; id = (k * 5 + fn * 3) % 32;
        va = mcr[ia]; vb = mcr[ib];
        case (fn)
          0: r = va & vb;
          1: r = va | vb;
          2: r = va ^ vb;
          default: r = ~(va & vb);
        endcase
        bit_a = 5'(ia); bit_b = 5'(ib); bit_dst = 5'(id); bit_fn = 2'(fn);
        issue(2'd1);
        mcr[id] = r;
        chk("R5 bit logic", cr_out, mcr);
      end
    end

    // R6 R7 R8 R9 R10 branch sweep
    for (int c = 0; c < 4; c++) begin
      for (int ctl = 0; ctl < 32; ctl++) begin
        logic [7:0] ld, nctr;
        logic [4:0] bo;
        logic ctr_ok, cond_ok, tk, cb;
        int it, sel;
        it = c * 32 + ctl;
        case (c)
          0: ld = 8'd0;
          1: ld = 8'd1;
          2: ld = 8'd2;
          default: ld = 8'd5;
        endcase
        count_in = ld;
        issue(2'd3);
        mctr = ld;
        chk("R10 count load", {24'h0, count_out}, {24'h0, ld});
        bo = 5'(ctl);
        sel = (ctl * 3 + c * 5) % 32;
        cb = mcr[sel];
        nctr = bo[2] ? mctr : mctr - 8'd1;
        ctr_ok = bo[2] || ((nctr == 8'd0) == bo[1]);
        cond_ok = bo[4] || (cb == bo[3]);
        tk = ctr_ok && cond_ok;
        pc = 16'h1000 + 16'(it * 4);
        target = 16'h8000 ^ 16'(it * 8);
        br_ctl = bo; cond_sel = 5'(sel);
        issue(2'd2);
        mctr = nctr;
        if (bo[0]) mlr = pc + 16'd4;
        chk("R6 R7 taken", {31'h0, taken}, {31'h0, tk});
        chk("R8 next_pc", {16'h0, next_pc}, {16'h0, tk ? target : pc + 16'd4});
        chk("R8 done", {31'h0, br_done}, 32'h1);
        chk("R7 count after branch", {24'h0, count_out}, {24'h0, mctr});
        chk("R9 link", {16'h0, link_out}, {16'h0, mlr});
        chk("R2 cr unchanged by branch", cr_out, mcr);
        @(negedge clk);
        chk("R8 done drops", {31'h0, br_done}, 32'h0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule